// File: doc/BRIEF.md
# Gated Multiplexed Clock Fanout

This block takes two clock sources, a fast system clock and a slower scan/test clock, and picks one of them with a source-select input. It copies the chosen clock onto six output lanes. Each lane drives a true pin and a complement pin. A lane can be stopped by a common stop input that acts on every lane, or by its own per-lane stop input.

Each lane has a small two-state machine. The states are `LANE_OFF` and `LANE_ON`. The machine advances only on the falling edge of the chosen clock. The transition `ARM` (`LANE_OFF` to `LANE_ON`) fires when neither the common stop nor the lane's own stop is asserted. The transition `PARK` (`LANE_ON` to `LANE_OFF`) fires when either stop is asserted. In all other cases the state holds. Because the state only changes while the chosen clock is low, a lane starts or stops only during a low phase. As a result, every high pulse at an output is a complete high phase of the source clock.

An active-low asynchronous reset forces every lane into `LANE_OFF`. Switching the source select while both clocks are running is outside the block's guarantees. Callers change it only while every lane is stopped.

Top module: `gated_clk_fanout`

## Requirements
- R1: A lane in `LANE_ON` drives its true pin high exactly while the chosen clock is high and low while it is low.
- R2: Source select 0 chooses the system clock and source select 1 chooses the scan clock, for all lanes.
- R3: While the common stop (1 = stop) is sampled high at a falling edge, every lane is in `LANE_OFF` from that edge on.
- R4: A lane's own stop bit (bit i of the stop vector, 1 = stop) parks only lane i. The other lanes keep running.
- R5: A stop takes effect at the next falling edge of the chosen clock and not before it. The true pin then stays low.
- R6: A lane is re-armed at the first falling edge at which both of its stops are low. Its first output pulse is the full high phase that follows.
- R7: Every high pulse on any true pin lasts exactly one high phase of the chosen clock, so no pulse is ever shortened.
- R8: Each complement pin is the inverse of its true pin. A parked lane shows true low and complement high.
- R9: While reset is low, every lane is in `LANE_OFF` and all true pins are low. A reset released during a high phase produces no pulse until after the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock source |
| scan_clk | input | 1 | Slow scan/test clock source |
| src_sel | input | 1 | Source select: 0 system, 1 scan |
| rst_n | input | 1 | Active-low asynchronous reset, parks all lanes |
| stop_all | input | 1 | Common stop for every lane, 1 = stop |
| stop_out | input | NUM_OUT | Per-lane stop, bit i stops lane i |
| clk_out_t | output | NUM_OUT | True clock outputs |
| clk_out_c | output | NUM_OUT | Complement clock outputs |

## Verification
At every falling edge of the chosen clock, the assertions check that a sampled common or own stop leaves the true pin low through the next high phase. They also check that a lane with no stop shows true high and complement low during that phase. The directed scenarios are needed for the remaining properties. These are: that a change waits for the falling edge and does not act within the current high phase, that the select really routes the slower clock, and that reset release mid-phase is clean. A pulse monitor in the bench measures every output pulse width against the chosen clock's half period. This is the only check of the no-runt property across all control patterns.

// File: rtl/gcf_pkg.sv
`timescale 1ns/1ps
package gcf_pkg;

    typedef enum logic {
        LANE_OFF = 1'b0,
        LANE_ON  = 1'b1
    } lane_state_e;

    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_SCAN = 1'b1
    } src_e;

endpackage

// File: rtl/gcf_src_mux.sv
`timescale 1ns/1ps
module gcf_src_mux
    import gcf_pkg::*;
(
    input  logic sys_clk,
    input  logic scan_clk,
    input  logic src_sel,
    output logic pick_clk
);

    src_e src;
    assign src = src_e'(src_sel);

    always_comb begin
        unique case (src)
            SRC_SCAN: pick_clk = scan_clk;
            SRC_SYS:  pick_clk = sys_clk;
            default:  pick_clk = sys_clk;
        endcase
    end

endmodule

// File: rtl/gcf_lane.sv
`timescale 1ns/1ps
module gcf_lane
    import gcf_pkg::*;
(
    input  logic pick_clk,
    input  logic rst_n,
    input  logic stop_all,
    input  logic stop_own,
    output logic out_t,
    output logic out_c
);

    lane_state_e state_q;
    lane_state_e state_d;
    logic        go;

    // A lane may run only when no stop source is asserted
    assign go = !(stop_all || stop_own);

    // Next-state decode: ARM and PARK transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_OFF: if (go)  state_d = LANE_ON;
            LANE_ON:  if (!go) state_d = LANE_OFF;
            default:           state_d = LANE_OFF;
        endcase
    end

    // State register: falling edge of the chosen clock, so changes land in the low phase
    always_ff @(negedge pick_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        out_t = (state_q == LANE_ON) && pick_clk;
        out_c = !out_t;
    end

    // R4
    lane_own_stop_chk: assert property (@(negedge pick_clk) disable iff (!rst_n)
        stop_own |=> !out_t);

    // R1
    lane_pass_chk: assert property (@(negedge pick_clk) disable iff (!rst_n)
        (!stop_all && !stop_own) |=> (out_t && !out_c));

    // R8
    lane_parked_level_chk: assert property (@(negedge pick_clk) disable iff (!rst_n)
        (stop_all || stop_own) |=> (out_c && !out_t));

endmodule

// File: rtl/gated_clk_fanout.sv
`timescale 1ns/1ps
module gated_clk_fanout
    import gcf_pkg::*;
#(
    parameter int NUM_OUT = 6
) (
    input  logic               sys_clk,
    input  logic               scan_clk,
    input  logic               src_sel,
    input  logic               rst_n,
    input  logic               stop_all,
    input  logic [NUM_OUT-1:0] stop_out,
    output logic [NUM_OUT-1:0] clk_out_t,
    output logic [NUM_OUT-1:0] clk_out_c
);

    localparam int LANE_LAST = NUM_OUT - 1;

    logic pick_clk;

    gcf_src_mux u_src (
        .sys_clk  (sys_clk),
        .scan_clk (scan_clk),
        .src_sel  (src_sel),
        .pick_clk (pick_clk)
    );

    for (genvar i = 0; i <= LANE_LAST; i++) begin : g_lane
        gcf_lane u_lane (
            .pick_clk (pick_clk),
            .rst_n    (rst_n),
            .stop_all (stop_all),
            .stop_own (stop_out[i]),
            .out_t    (clk_out_t[i]),
            .out_c    (clk_out_c[i])
        );
    end

    // R3
    all_stop_chk: assert property (@(negedge pick_clk) disable iff (!rst_n)
        stop_all |=> (clk_out_t == '0));

endmodule

// File: tb/gated_clk_fanout_tb.sv
`timescale 1ns/1ps
module gated_clk_fanout_tb;

    localparam time CLK_PERIOD  = 10;
    localparam time SCAN_PERIOD = CLK_PERIOD * 4;
    localparam int  N           = 6;

    logic         sys_clk  = 1'b0;
    logic         scan_clk = 1'b0;
    logic         src_sel;
    logic         rst_n;
    logic         stop_all;
    logic [N-1:0] stop_out;
    logic [N-1:0] clk_out_t;
    logic [N-1:0] clk_out_c;
    logic         ref_clk;

    int n_chk  = 0;
    int n_bad  = 0;
    int pulses = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2)  sys_clk  = ~sys_clk;
    always #(SCAN_PERIOD/2) scan_clk = ~scan_clk;

    // R2: the chosen clock as the requirement defines it
    assign ref_clk = src_sel ? scan_clk : sys_clk;

    gated_clk_fanout #(.NUM_OUT(N)) u_dut (
        .sys_clk   (sys_clk),
        .scan_clk  (scan_clk),
        .src_sel   (src_sel),
        .rst_n     (rst_n),
        .stop_all  (stop_all),
        .stop_out  (stop_out),
        .clk_out_t (clk_out_t),
        .clk_out_c (clk_out_c)
    );

    task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_mask();
        return stop_all ? '0 : ~stop_out;
    endfunction

    task automatic high_check(input string req, input logic [N-1:0] exp);
        @(posedge ref_clk);
        #1;
        check_vec(req, clk_out_t, exp);
        check_vec("R8", clk_out_c, ~exp);
    endtask

    task automatic low_check(input string req);
        @(negedge ref_clk);
        #1;
        check_vec(req, clk_out_t, '0);
        check_vec("R8", clk_out_c, '1);
    endtask

    // Apply controls in a high phase; the old state must hold until the falling edge (R5)
    task automatic drive(input logic all, input logic [N-1:0] lanes, input string req);
        logic [N-1:0] old;
        @(posedge ref_clk);
        #1;
        old      = exp_mask();
        stop_all = all;
        stop_out = lanes;
        check_vec("R5", clk_out_t, old);
        high_check(req, exp_mask());
    endtask

    // R7: every pulse must last one high phase of the chosen clock
    for (genvar g = 0; g < N; g++) begin : g_mon
        time t_rise;
        bit  armed = 1'b0;
        always @(posedge clk_out_t[g]) begin
            if (rst_n === 1'b1 && clk_out_t[g] === 1'b1) begin
                t_rise = $time;
                armed  = 1'b1;
            end
        end
        always @(negedge clk_out_t[g]) begin
            if (armed) begin
                armed = 1'b0;
                pulses++;
                n_chk++;
                if (($time - t_rise) != (src_sel ? SCAN_PERIOD/2 : CLK_PERIOD/2)) begin
                    n_bad++;
                    $display("FAIL R7: lane %0d actual width %0t expected %0t", g,
                             $time - t_rise, src_sel ? SCAN_PERIOD/2 : CLK_PERIOD/2);
                end
            end
        end
    end

    task automatic t_reset();
        high_check("R9", '0);
        high_check("R9", '0);
        @(posedge ref_clk);
        #1;
        rst_n = 1'b1;
        check_vec("R9", clk_out_t, '0);
        high_check("R1", '1);
        low_check("R1");
        high_check("R1", '1);
    endtask

    task automatic t_lanes();
        drive(1'b0, 6'b000101, "R4");
        drive(1'b0, 6'b111000, "R4");
        low_check("R5");
        drive(1'b0, 6'b000000, "R6");
        high_check("R6", '1);
    endtask

    task automatic t_common();
        drive(1'b1, 6'b000000, "R3");
        drive(1'b1, 6'b010101, "R3");
        low_check("R3");
        drive(1'b0, 6'b010101, "R6");
        drive(1'b0, 6'b000000, "R6");
    endtask

    task automatic t_scan();
        drive(1'b1, 6'b000000, "R3");
        @(negedge scan_clk);
        #7;
        src_sel = 1'b1;
        drive(1'b0, 6'b000000, "R2");
        @(posedge ref_clk);
        #(SCAN_PERIOD/2 - 2);
        check_vec("R2", clk_out_t, '1);
        low_check("R2");
        drive(1'b0, 6'b100001, "R4");
        drive(1'b1, 6'b000000, "R3");
        @(negedge scan_clk);
        #7;
        src_sel = 1'b0;
        drive(1'b0, 6'b000000, "R2");
        @(posedge ref_clk);
        #(CLK_PERIOD/2 + 1);
        check_vec("R2", clk_out_t, '0);
    endtask

    initial begin
        src_sel  = 1'b0;
        rst_n    = 1'b0;
        stop_all = 1'b0;
        stop_out = '0;
        t_reset();
        t_lanes();
        t_common();
        t_scan();
        n_chk++;
        if (pulses == 0) begin
            n_bad++;
            $display("FAIL R7: actual %0d pulses expected more than 0", pulses);
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule